// File: doc/BRIEF.md
# OSD Bitmap Pixel Compositor

This block mixes one on-screen-display bitmap pixel over one video pixel per clock. The mix weight is a three-bit factor counted in eighths. A colour-key test can make an OSD pixel fully see-through. In attribute mode, a four-bit code supplied with each pixel gives its own mix factor and a blink flag. A timer counts frame pulses and sets the blink phase.

The OSD pixel arrives either as packed 24-bit RGB or as 16-bit RGB565, which the block widens to full channel width. Each of two bitmap windows has its own range-compression switch. The switch for the selected window squeezes every OSD channel into the 16..235 range before the mix. Colour lookup, YUV conversion and window placement happen elsewhere. The result is a registered RGB pixel with a valid flag.

Top module: `osd_blend_top`

## Requirements
- R1: `out_valid` equals `vid_valid` from the previous clock edge. `out_rgb` is updated one cycle after each pixel where `vid_valid` is high.
- R2: With effective factor n in 0..6, each channel (R in bits 23:16, G in 15:8, B in 7:0) becomes floor((osd·n + video·(8−n))/8). Factor 0 yields the video pixel unchanged.
- R3: Factor 7 is the full-OSD setting. The output equals the (widened) OSD pixel and has no video share.
- R4: When `osd_valid` is low with a valid video pixel, the output is the video pixel.
- R5: With `key_en` high in 24-bit mode, an OSD pixel equal to {`key_hi`,`key_lo`} outputs the video pixel. A pixel differing in any bit is blended normally.
- R6: With `fmt_565` high, `osd_px[15:0]` holds R in 15:11, G in 10:5 and B in 4:0. Each field is widened by repeating its top bits (R,B: {x, x[4:2]}; G: {x, x[5:4]}). The colour key then compares against `key_lo` only.
- R7: When bit `win_sel` of `atten_en` is set, each OSD channel c becomes 16 + floor(c·220/256) before mixing. The colour key still tests the unscaled OSD value. The other window's bit has no effect.
- R8: With `attr_en` high, `attr_code[2:0]` replaces `blend_n` as the factor.
- R9: With `attr_en`, `attr_code[3]` and `blink_en` all high, the output is the video pixel during the off phase. The phase starts visible after reset. It toggles on every (`blink_int`+1)-th frame pulse. While `blink_en` is low the phase is held visible and the count restarts.
- R10: After reset `out_valid` and `out_rgb` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_valid | input | 1 | Video pixel present |
| vid_rgb | input | 24 | Video pixel, R/G/B high to low |
| osd_valid | input | 1 | OSD pixel present |
| osd_px | input | 24 | OSD pixel, 24-bit RGB or RGB565 in low half |
| fmt_565 | input | 1 | OSD pixel is RGB565 |
| win_sel | input | 1 | Which bitmap window this pixel belongs to |
| atten_en | input | 2 | Range-compression switch per window |
| blend_n | input | 3 | Static mix factor in eighths |
| key_en | input | 1 | Colour-key transparency on |
| key_lo | input | 16 | Key low part (G,B or whole RGB565 key) |
| key_hi | input | 8 | Key upper byte (R) for 24-bit mode |
| attr_en | input | 1 | Take factor and blink flag from attribute code |
| attr_code | input | 4 | Bit 3 blink flag, bits 2:0 factor |
| blink_en | input | 1 | Global blink enable |
| blink_int | input | 8 | Frame pulses per blink phase, minus one |
| frame_pulse | input | 1 | One-cycle frame start strobe |
| out_valid | output | 1 | Blended pixel present |
| out_rgb | output | 24 | Blended pixel |

## Verification
Every blended pixel is due exactly one clock edge after the edge that samples its inputs. The driver applies each pixel on a falling edge and pushes its expected value at that moment. The monitor pops and compares two nanoseconds after the next rising edge, so at most one item is ever in flight. A blink phase change takes effect at the edge that samples a frame pulse. The driver therefore updates its phase model when it applies the pulse, and any later pixel meets the new phase in both model and design. Idle cycles are checked the same way: the edge after an idle cycle must show `out_valid` low.

// File: rtl/osd_blend_pkg.sv
package osd_blend_pkg;
   // attribute code layout
   localparam int ATTR_W     = 4;
   localparam int ATTR_BLINK = 3;
   localparam int FACT_W     = 3;
   localparam int WT_W       = 4;

   // factor in eighths to weight; the top code means the OSD pixel alone
   function automatic logic [WT_W-1:0] weight_of(input logic [FACT_W-1:0] n);
      return (n == {FACT_W{1'b1}}) ? WT_W'(8) : WT_W'(n);
   endfunction
endpackage

// File: rtl/osd_chan_atten.sv
module osd_chan_atten #(
   parameter int CH_W = 8
) (
   input  logic            en,
   input  logic [CH_W-1:0] c_in,
   output logic [CH_W-1:0] c_out
);
   localparam int LO   = 16 << (CH_W - 8);
   localparam int SPAN = 220 << (CH_W - 8);
   localparam int PW   = CH_W + 12;

   logic [PW-1:0] prod;
   logic [PW-1:0] scaled;

   always_comb begin
      prod   = PW'(c_in) * PW'(SPAN);
      scaled = PW'(LO) + (prod >> CH_W);
      c_out  = en ? scaled[CH_W-1:0] : c_in;
   end
endmodule

// File: rtl/osd_chan_mix.sv
module osd_chan_mix #(
   parameter int CH_W = 8
) (
   input  logic [CH_W-1:0] osd_c,
   input  logic [CH_W-1:0] vid_c,
   input  logic [3:0]      wt,
   output logic [CH_W-1:0] mix_c
);
   localparam int AW = CH_W + 4;

   logic [AW-1:0] acc;
   logic [AW-1:0] sh;

   always_comb begin
      acc   = AW'(osd_c) * AW'(wt) + AW'(vid_c) * AW'(4'd8 - wt);
      sh    = acc >> 3;
      mix_c = sh[CH_W-1:0];
   end
endmodule

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
   parameter int BLINK_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               blink_en,
   input  logic               frame_pulse,
   input  logic [BLINK_W-1:0] interval,
   output logic               show
);
   logic [BLINK_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !blink_en) begin
         cnt  <= '0;
         show <= 1'b1;
      end else if (frame_pulse) begin
         if (cnt >= interval) begin
            cnt  <= '0;
            show <= ~show;
         end else begin
            cnt  <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/osd_blend_top.sv
module osd_blend_top #(
   parameter int CH_W    = 8,
   parameter int BLINK_W = 8,
   parameter int N_WIN   = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  vid_valid,
   input  logic [3*CH_W-1:0]     vid_rgb,
   input  logic                  osd_valid,
   input  logic [3*CH_W-1:0]     osd_px,
   input  logic                  fmt_565,
   input  logic [$clog2(N_WIN)-1:0] win_sel,
   input  logic [N_WIN-1:0]      atten_en,
   input  logic [2:0]            blend_n,
   input  logic                  key_en,
   input  logic [2*CH_W-1:0]     key_lo,
   input  logic [CH_W-1:0]       key_hi,
   input  logic                  attr_en,
   input  logic [3:0]            attr_code,
   input  logic                  blink_en,
   input  logic [BLINK_W-1:0]    blink_int,
   input  logic                  frame_pulse,
   output logic                  out_valid,
   output logic [3*CH_W-1:0]     out_rgb
);
   import osd_blend_pkg::*;

   localparam int PIX_W = 3 * CH_W;

   if (CH_W < 8 || CH_W > 12) begin : g_bad_ch
      $error("CH_W must lie in 8..12");
   end
   if (N_WIN < 2) begin : g_bad_win
      $error("N_WIN must be at least 2");
   end
   if (BLINK_W < 1) begin : g_bad_blink
      $error("BLINK_W must be positive");
   end

   // ---------------- OSD pixel widening ----------------
   logic [14:0]      r_rep, b_rep;
   logic [11:0]      g_rep;
   logic [PIX_W-1:0] osd_wide;

   always_comb begin
      r_rep = {3{osd_px[15:11]}};
      g_rep = {2{osd_px[10:5]}};
      b_rep = {3{osd_px[4:0]}};
      if (fmt_565)
         osd_wide = {r_rep[14 -: CH_W], g_rep[11 -: CH_W], b_rep[14 -: CH_W]};
      else
         osd_wide = osd_px;
   end

   // ---------------- colour key on the raw pixel ----------------
   logic key_hit;
   always_comb begin
      if (fmt_565)
         key_hit = key_en && (osd_px[15:0] == key_lo[15:0]);
      else
         key_hit = key_en && (osd_px == {key_hi, key_lo});
   end

   // ---------------- blink phase ----------------
   logic blink_show;
   osd_blink_timer #(.BLINK_W(BLINK_W)) u_blink (
      .clk         (clk),
      .rst_n       (rst_n),
      .blink_en    (blink_en),
      .frame_pulse (frame_pulse),
      .interval    (blink_int),
      .show        (blink_show)
   );

   // ---------------- weight selection ----------------
   logic [FACT_W-1:0] fact;
   logic              hide;
   logic [WT_W-1:0]   wt;
   logic              atten_on;

   always_comb begin
      fact     = attr_en ? attr_code[FACT_W-1:0] : blend_n;
      hide     = attr_en && attr_code[ATTR_BLINK] && blink_en && !blink_show;
      wt       = (!osd_valid || key_hit || hide) ? '0 : weight_of(fact);
      atten_on = atten_en[win_sel];
   end

   // ---------------- per-channel datapath ----------------
   logic [PIX_W-1:0] mixed;

   for (genvar ch = 0; ch < 3; ch++) begin : g_ch
      logic [CH_W-1:0] osd_sc;
      osd_chan_atten #(.CH_W(CH_W)) u_att (
         .en    (atten_on),
         .c_in  (osd_wide[ch*CH_W +: CH_W]),
         .c_out (osd_sc)
      );
      osd_chan_mix #(.CH_W(CH_W)) u_mix (
         .osd_c (osd_sc),
         .vid_c (vid_rgb[ch*CH_W +: CH_W]),
         .wt    (wt),
         .mix_c (mixed[ch*CH_W +: CH_W])
      );
   end

   // ---------------- output register ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_rgb   <= '0;
      end else begin
         out_valid <= vid_valid;
         if (vid_valid) out_rgb <= mixed;
      end
   end
endmodule

// File: rtl/osd_blend_chk.sv
module osd_blend_chk #(
   parameter int CH_W  = 8,
   parameter int N_WIN = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     vid_valid,
   input logic [3*CH_W-1:0]        vid_rgb,
   input logic                     osd_valid,
   input logic [3*CH_W-1:0]        osd_px,
   input logic                     fmt_565,
   input logic [$clog2(N_WIN)-1:0] win_sel,
   input logic [N_WIN-1:0]         atten_en,
   input logic [2:0]               blend_n,
   input logic                     key_en,
   input logic [2*CH_W-1:0]        key_lo,
   input logic [CH_W-1:0]          key_hi,
   input logic                     attr_en,
   input logic                     out_valid,
   input logic [3*CH_W-1:0]        out_rgb
);
   // R1
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vid_valid |=> out_valid);

   // R1
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_valid |=> !out_valid);

   // R4
   no_osd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_valid && !osd_valid) |=> (out_rgb == $past(vid_rgb)));

   // R5
   key_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_valid && key_en && !fmt_565 && osd_px == {key_hi, key_lo})
      |=> (out_rgb == $past(vid_rgb)));

   // R2
   zero_factor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_valid && !attr_en && blend_n == 3'd0) |=> (out_rgb == $past(vid_rgb)));

   // R3
   full_osd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_valid && osd_valid && !attr_en && !key_en && !fmt_565
       && blend_n == 3'd7 && !atten_en[win_sel])
      |=> (out_rgb == $past(osd_px)));
endmodule

bind osd_blend_top osd_blend_chk #(.CH_W(CH_W), .N_WIN(N_WIN)) u_chk (.*);

// File: tb/osd_blend_top_tb.sv
module osd_blend_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vid_valid = 1'b0, osd_valid = 1'b0;
   logic [23:0] vid_rgb = '0, osd_px = '0;
   logic        fmt_565 = 1'b0, win_sel = 1'b0, key_en = 1'b0;
   logic [1:0]  atten_en = '0;
   logic [2:0]  blend_n = '0;
   logic [15:0] key_lo = '0;
   logic [7:0]  key_hi = '0;
   logic        attr_en = 1'b0, blink_en = 1'b0, frame_pulse = 1'b0;
   logic [3:0]  attr_code = '0;
   logic [7:0]  blink_int = '0;
   logic        out_valid;
   logic [23:0] out_rgb;

   // settings shadowed in the bench, copied to the pins on a falling edge
   logic        s_565 = 0, s_win = 0, s_key_en = 0, s_attr_en = 0, s_blink_en = 0;
   logic [1:0]  s_atten = 0;
   logic [2:0]  s_n = 0;
   logic [15:0] s_klo = 0;
   logic [7:0]  s_khi = 0, s_bint = 0;
   logic [3:0]  s_attr = 0;

   int          m_cnt = 0;
   logic        m_show = 1'b1;

   int compared = 0, mismatched = 0;
   logic [23:0] exp_q[$];
   string       tag_q[$];
   logic        idle_due = 1'b0;
   string       idle_tag = "";
   logic        done = 1'b0;

   always #4 clk = ~clk;

   osd_blend_top u_dut (.*);

   task automatic apply_settings();
      fmt_565 = s_565; win_sel = s_win; atten_en = s_atten; blend_n = s_n;
      key_en = s_key_en; key_lo = s_klo; key_hi = s_khi; attr_en = s_attr_en;
      attr_code = s_attr; blink_en = s_blink_en; blink_int = s_bint;
      if (!s_blink_en) begin m_cnt = 0; m_show = 1'b1; end
   endtask

   function automatic logic [23:0] model(input logic [23:0] v, input logic [23:0] o,
                                         input logic ov);
      logic [23:0] ow;
      logic        hit, hide;
      logic [2:0]  f;
      int          w, oc, vc;
      logic [23:0] r;
      if (s_565) ow = {o[15:11], o[15:13], o[10:5], o[10:9], o[4:0], o[4:2]};
      else       ow = o;
      hit  = s_key_en && (s_565 ? (o[15:0] == s_klo) : (o == {s_khi, s_klo}));
      f    = s_attr_en ? s_attr[2:0] : s_n;
      hide = s_attr_en && s_attr[3] && s_blink_en && !m_show;
      w    = (f == 3'd7) ? 8 : int'(f);
      if (!ov || hit || hide) w = 0;
      for (int c = 0; c < 3; c++) begin
         oc = int'(ow[c*8 +: 8]);
         vc = int'(v[c*8 +: 8]);
         if (s_atten[s_win]) oc = 16 + (oc * 220) / 256;
         r[c*8 +: 8] = 8'((oc * w + vc * (8 - w)) / 8);
      end
      return r;
   endfunction

   task automatic pix(input logic [23:0] v, input logic [23:0] o, input logic ov,
                      input string tag);
      @(negedge clk);
      apply_settings();
      frame_pulse = 1'b0;
      vid_valid = 1'b1; osd_valid = ov; vid_rgb = v; osd_px = o;
      exp_q.push_back(model(v, o, ov));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      apply_settings();
      vid_valid = 1'b0; osd_valid = 1'b0; frame_pulse = 1'b0;
      idle_due = 1'b1; idle_tag = tag;
   endtask

   task automatic frame();
      @(negedge clk);
      apply_settings();
      vid_valid = 1'b0; frame_pulse = 1'b1;
      if (s_blink_en) begin
         if (m_cnt >= int'(s_bint)) begin m_cnt = 0; m_show = ~m_show; end
         else m_cnt++;
      end
   endtask

   // monitor: one item is due at each rising edge after it was driven
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         if (exp_q.size() > 0) begin
            logic [23:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (!out_valid || out_rgb !== e) begin
               mismatched++;
               $display("FAIL %s: out_valid=%0b out_rgb=%06h expected valid=1 rgb=%06h",
                        t, out_valid, out_rgb, e);
            end
         end else if (idle_due) begin
            compared++;
            if (out_valid !== 1'b0) begin
               mismatched++;
               $display("FAIL %s: out_valid=%0b expected 0", idle_tag, out_valid);
            end
         end else if (out_valid === 1'b1) begin
            mismatched++;
            $display("FAIL R1: out_valid=1 expected 0 (nothing due)");
         end
         idle_due = 1'b0;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: run still busy, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      compared++;
      if (out_valid !== 1'b0 || out_rgb !== 24'h0) begin
         mismatched++;
         $display("FAIL R10: valid=%0b rgb=%06h expected 0/000000", out_valid, out_rgb);
      end
      rst_n = 1'b1;

      // R2: factor 0 and several fractional factors
      s_n = 3'd0; pix(24'h102030, 24'hF0E0D0, 1'b1, "R2 n0");
      s_n = 3'd3; pix(24'h102030, 24'hF0E0D0, 1'b1, "R2 n3");
      s_n = 3'd5; pix(24'hFF0000, 24'h00FF80, 1'b1, "R2 n5");
      s_n = 3'd6; pix(24'h000000, 24'hFFFFFF, 1'b1, "R2 n6");
      // R3: top factor is OSD only
      s_n = 3'd7; pix(24'h123456, 24'hABCDEF, 1'b1, "R3 full");
      // R1: gap then stream
      idle("R1 idle");
      pix(24'h0, 24'h010203, 1'b1, "R1 stream");
      // R4: OSD absent
      s_n = 3'd4; pix(24'h445566, 24'hFFFFFF, 1'b0, "R4 no osd");

      // R5: key in 24-bit mode
      s_key_en = 1; s_khi = 8'hAA; s_klo = 16'hBBCC; s_n = 3'd7;
      pix(24'h112233, 24'hAABBCC, 1'b1, "R5 key hit");
      pix(24'h112233, 24'hAABBCD, 1'b1, "R5 key miss");

      // R6: RGB565 widening and 16-bit key
      s_565 = 1; s_key_en = 0;
      pix(24'h000000, 24'h00F81F, 1'b1, "R6 widen");
      pix(24'h000000, 24'h0007E0, 1'b1, "R6 widen g");
      s_key_en = 1; s_klo = 16'h07E0; s_khi = 8'h55;
      pix(24'h778899, 24'hFF07E0, 1'b1, "R6 key16");
      s_565 = 0; s_key_en = 0;

      // R7: range compression per window
      s_atten = 2'b01; s_win = 0; s_n = 3'd7;
      pix(24'h000000, 24'hFF0080, 1'b1, "R7 win0 on");
      s_win = 1;
      pix(24'h000000, 24'hFF0080, 1'b1, "R7 win1 off");
      s_win = 0; s_key_en = 1; s_khi = 8'hFF; s_klo = 16'h0080;
      pix(24'h010101, 24'hFF0080, 1'b1, "R7 key raw");
      s_key_en = 0; s_atten = 2'b00;

      // R8: attribute factor overrides static factor
      s_attr_en = 1; s_attr = 4'h2; s_n = 3'd7;
      pix(24'h808080, 24'h000000, 1'b1, "R8 attr n2");
      s_attr = 4'h7;
      pix(24'h808080, 24'h204060, 1'b1, "R8 attr n7");

      // R9: blink phases, interval of two frames
      s_blink_en = 1; s_bint = 8'd1; s_attr = 4'hF;
      pix(24'h111111, 24'hEEEEEE, 1'b1, "R9 visible at start");
      frame();
      pix(24'h111111, 24'hEEEEEE, 1'b1, "R9 visible after 1 frame");
      frame();
      pix(24'h111111, 24'hEEEEEE, 1'b1, "R9 hidden");
      s_attr = 4'h7;
      pix(24'h111111, 24'hEEEEEE, 1'b1, "R9 no flag shown");
      s_attr = 4'hF;
      frame();
      pix(24'h111111, 24'hEEEEEE, 1'b1, "R9 still hidden");
      frame();
      pix(24'h111111, 24'hEEEEEE, 1'b1, "R9 visible again");
      frame(); frame();
      pix(24'h111111, 24'hEEEEEE, 1'b1, "R9 hidden again");
      s_blink_en = 0;
      pix(24'h111111, 24'hEEEEEE, 1'b1, "R9 global off");
      s_blink_en = 1;
      frame();
      pix(24'h111111, 24'hEEEEEE, 1'b1, "R9 restart count");

      idle("R1 final idle");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      if (exp_q.size() != 0) begin
         mismatched++;
         $display("FAIL R1: %0d results outstanding, expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule